// File: doc/BRIEF.md
# Pulse-Width-Qualified Trigger Gate

This block stops a downstream timed event sequencer until an external logic signal meets a chosen condition, and then lets it run. Several asynchronous logic inputs come in, and each one is synchronized. While the gate is in its idle state, a configuration write selects one input, a mode, a polarity and a minimum width. Arming the gate raises `hold_o`, which the sequencer must obey. When the condition is met, `hold_o` drops and a one-cycle release strobe is issued. The same strobe comes with the cycle count at which the qualifying edge was seen.

There are two modes. Edge mode fires on a single rising or falling edge. Interval mode fires only on a complete pulse (a high pulse or a low pulse) whose width, counted in system-clock cycles, reaches a programmed minimum. Shorter pulses, such as coupling glitches from neighbouring cables, are discarded and the gate stays armed. After a release the gate returns to idle. It can then be reconfigured and armed on any other input, so one sequence can wait several times on different signals. An abort input drops an armed gate back to idle without releasing.

Top module: `trig_gate`

## Requirements
- R1: After reset, `hold_o`, `rel_o` and `ts_valid_o` are all 0.
- R2: One clock edge after `arm` is sampled high in idle, `hold_o` is 1. It stays 1 until a qualifying event or an abort.
- R3: In edge mode (`cfg_mode`=0), `cfg_pol`=0 qualifies on a rising edge and `cfg_pol`=1 qualifies on a falling edge of the selected input.
- R4: In interval mode (`cfg_mode`=1), a pulse is accepted only if the synchronized input stays at its active level for at least `cfg_width` clock cycles. A shorter pulse causes no release and the gate remains holding.
- R5: In interval mode, `cfg_pol`=0 selects a high pulse (rise then fall) and `cfg_pol`=1 selects a low pulse (fall then rise).
- R6: `cfg_chan` selects which bit of `trig_in` is watched. Activity on every other bit has no effect.
- R7: Release latency is fixed. `rel_o` is 1 and `hold_o` is 0 in the cycle that follows the third rising clock edge after the qualifying input change. That is two synchronizer edges plus one state edge.
- R8: `rel_o` and `ts_valid_o` are single-cycle strobes. `ts_o` then equals the number of clock edges since reset release, counted up to the cycle before the strobe.
- R9: `abort` while holding returns the gate to idle with no release. If `abort` and a qualifying event fall in the same cycle, the abort wins.
- R10: A configuration write while the gate is not idle is ignored.
- R11: After a release, the gate can be reconfigured to a different channel and armed again, and it releases on the new channel.
- R12: In interval mode, a `cfg_width` of 0 behaves as 1, so any complete pulse is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_in | input | NUM_CH | Asynchronous external logic inputs |
| cfg_we | input | 1 | Configuration write strobe, honoured only in idle |
| cfg_chan | input | CH_W | Watched input index |
| cfg_mode | input | 1 | 0 edge mode, 1 interval mode |
| cfg_pol | input | 1 | Edge: 0 rising, 1 falling; interval: 0 high pulse, 1 low pulse |
| cfg_width | input | WIDTH_W | Minimum pulse width in clock cycles |
| arm | input | 1 | Arm request, honoured only in idle |
| abort | input | 1 | Return to idle without releasing |
| hold_o | output | 1 | Downstream sequencer must not advance while 1 |
| rel_o | output | 1 | One-cycle release strobe |
| ts_o | output | TS_W | Cycle count at the qualifying edge |
| ts_valid_o | output | 1 | One-cycle strobe marking `ts_o` valid |

## Verification
An abort and a qualifying edge can land in the same clock cycle. The bench raises `abort` in exactly the cycle in which the synchronized edge of an armed rising-edge wait becomes visible. That cycle is two clock edges after the input change. One edge later the bench expects `hold_o` low, `rel_o` low, and no release in the cycles that follow. A second collision case is a configuration write that arrives while the gate is armed. The bench judges it by showing that a pulse on the newly written channel releases nothing, while a pulse on the original channel still does.

// File: rtl/tg_pkg.sv
package tg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_ARMED    = 2'd1,
    ST_IN_PULSE = 2'd2,
    ST_RELEASED = 2'd3
  } tg_state_e;

  // Leading edge of the watched condition for a given polarity.
  function automatic logic lead_edge(input logic pol, input logic rise, input logic fall);
    return pol ? fall : rise;
  endfunction

  // Trailing edge: the opposite transition.
  function automatic logic trail_edge(input logic pol, input logic rise, input logic fall);
    return pol ? rise : fall;
  endfunction
endpackage

// File: rtl/tg_sync.sv
module tg_sync #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] din,
  output logic [NUM_CH-1:0] rise,
  output logic [NUM_CH-1:0] fall
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic meta_q, lvl_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        lvl_q  <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= din[g];
        lvl_q  <= meta_q;
        prev_q <= lvl_q;
      end
    end
    assign rise[g] = lvl_q & ~prev_q;
    assign fall[g] = ~lvl_q & prev_q;
  end
endmodule

// File: rtl/tg_width_ctr.sv
module tg_width_ctr #(
  parameter int WIDTH_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               inc,
  input  logic [WIDTH_W-1:0] tau,
  output logic               met
);
  logic [WIDTH_W-1:0] cnt_q;

  // Width zero is treated as one cycle.
  function automatic logic [WIDTH_W-1:0] eff_tau(input logic [WIDTH_W-1:0] t);
    return (t == '0) ? WIDTH_W'(1) : t;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (start)
      cnt_q <= WIDTH_W'(1);
    else if (inc && (cnt_q < eff_tau(tau)))
      cnt_q <= cnt_q + WIDTH_W'(1);
  end

  assign met = (cnt_q >= eff_tau(tau));
endmodule

// File: rtl/trig_gate.sv
module trig_gate #(
  parameter int NUM_CH  = 4,
  parameter int WIDTH_W = 16,
  parameter int TS_W    = 32,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CH-1:0]  trig_in,
  input  logic               cfg_we,
  input  logic [CH_W-1:0]    cfg_chan,
  input  logic               cfg_mode,
  input  logic               cfg_pol,
  input  logic [WIDTH_W-1:0] cfg_width,
  input  logic               arm,
  input  logic               abort,
  output logic               hold_o,
  output logic               rel_o,
  output logic [TS_W-1:0]    ts_o,
  output logic               ts_valid_o
);
  import tg_pkg::*;

  tg_state_e          state_q, state_d;
  logic [CH_W-1:0]    chan_q;
  logic               mode_q, pol_q;
  logic [WIDTH_W-1:0] width_q;
  logic [TS_W-1:0]    now_q, ts_q;
  logic [NUM_CH-1:0]  rise_v, fall_v;

  // Named internal events for the checker.
  logic in_idle, in_armed, in_pulse;
  logic sel_rise, sel_fall, lead_evt, trail_evt, width_met;
  logic start_pulse, qual_raw;

  tg_sync #(.NUM_CH(NUM_CH)) u_sync (
    .clk (clk), .rst_n (rst_n), .din (trig_in), .rise (rise_v), .fall (fall_v)
  );

  assign in_idle   = (state_q == ST_IDLE);
  assign in_armed  = (state_q == ST_ARMED);
  assign in_pulse  = (state_q == ST_IN_PULSE);
  assign sel_rise  = rise_v[chan_q];
  assign sel_fall  = fall_v[chan_q];
  assign lead_evt  = lead_edge(pol_q, sel_rise, sel_fall);
  assign trail_evt = trail_edge(pol_q, sel_rise, sel_fall);

  assign start_pulse = in_armed && mode_q && lead_evt && !abort;

  tg_width_ctr #(.WIDTH_W(WIDTH_W)) u_width (
    .clk (clk), .rst_n (rst_n), .start (start_pulse),
    .inc (in_pulse && !trail_evt), .tau (width_q), .met (width_met)
  );

  assign qual_raw = (in_armed && !mode_q && lead_evt) ||
                    (in_pulse && trail_evt && width_met);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (arm) state_d = ST_ARMED;
      ST_ARMED: begin
        if (abort)                 state_d = ST_IDLE;
        else if (qual_raw)         state_d = ST_RELEASED;
        else if (start_pulse)      state_d = ST_IN_PULSE;
      end
      ST_IN_PULSE: begin
        if (abort)                 state_d = ST_IDLE;
        else if (qual_raw)         state_d = ST_RELEASED;
        else if (trail_evt)        state_d = ST_ARMED;
      end
      ST_RELEASED:                 state_d = ST_IDLE;
      default:                     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      chan_q  <= '0;
      mode_q  <= 1'b0;
      pol_q   <= 1'b0;
      width_q <= '0;
      now_q   <= '0;
      ts_q    <= '0;
    end else begin
      state_q <= state_d;
      now_q   <= now_q + TS_W'(1);
      if (in_idle && cfg_we) begin
        chan_q  <= cfg_chan;
        mode_q  <= cfg_mode;
        pol_q   <= cfg_pol;
        width_q <= cfg_width;
      end
      if (qual_raw && !abort) ts_q <= now_q;
    end
  end

  assign hold_o     = in_armed || in_pulse;
  assign rel_o      = (state_q == ST_RELEASED);
  assign ts_valid_o = rel_o;
  assign ts_o       = ts_q;
endmodule

// File: rtl/tg_chk.sv
module tg_chk #(
  parameter int CH_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hold_o,
  input logic            rel_o,
  input logic            ts_valid_o,
  input logic            abort,
  input logic            qual_raw,
  input logic            in_idle,
  input logic [CH_W-1:0] chan_q,
  input logic            mode_q,
  input logic            pol_q
);
  assert_rel_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rel_o |=> !rel_o);

  assert_valid_from_qual_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ts_valid_o |-> $past(qual_raw));

  assert_rel_no_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rel_o |-> !hold_o);

  assert_qual_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && qual_raw && !abort) |=> rel_o);

  assert_abort_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && abort) |=> (!rel_o && !hold_o));

  assert_hold_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && !qual_raw && !abort) |=> hold_o);

  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_idle |=> $stable({chan_q, mode_q, pol_q}));
endmodule

bind trig_gate tg_chk #(.CH_W(CH_W)) u_chk (
  .clk (clk), .rst_n (rst_n), .hold_o (hold_o), .rel_o (rel_o),
  .ts_valid_o (ts_valid_o), .abort (abort), .qual_raw (qual_raw),
  .in_idle (in_idle), .chan_q (chan_q), .mode_q (mode_q), .pol_q (pol_q)
);

// File: tb/trig_gate_tb_top.sv
module trig_gate_tb_top;
  localparam int NUM_CH = 4;
  localparam int WIDTH_W = 16;
  localparam int TS_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_CH-1:0] din = '0;
  logic cfg_we = 1'b0, cfg_mode = 1'b0, cfg_pol = 1'b0, arm = 1'b0, abort = 1'b0;
  logic [1:0] cfg_chan = '0;
  logic [WIDTH_W-1:0] cfg_width = '0;
  logic hold_o, rel_o, ts_valid_o;
  logic [TS_W-1:0] ts_o;

  int n_tests = 0, n_fail = 0;
  longint bc;

  always #10 clk = ~clk; // 50 MHz

  trig_gate #(.NUM_CH(NUM_CH), .WIDTH_W(WIDTH_W), .TS_W(TS_W)) dut_i (
    .clk (clk), .rst_n (rst_n), .trig_in (din), .cfg_we (cfg_we),
    .cfg_chan (cfg_chan), .cfg_mode (cfg_mode), .cfg_pol (cfg_pol),
    .cfg_width (cfg_width), .arm (arm), .abort (abort), .hold_o (hold_o),
    .rel_o (rel_o), .ts_o (ts_o), .ts_valid_o (ts_valid_o)
  );

  // Bench copy of "edges since reset release" from R8.
  always @(posedge clk) begin
    if (!rst_n) bc <= 0;
    else        bc <= bc + 1;
  end

  typedef struct packed {
    logic [1:0] ch;
    logic       mode;
    logic       pol;
    logic [7:0] tau;
    logic [1:0] pch;
    logic       idle;
    logic [7:0] len;
    logic       exp;
    logic [3:0] tag;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{ch:2'd0, mode:1'b0, pol:1'b0, tau:8'd0, pch:2'd0, idle:1'b0, len:8'd3, exp:1'b1, tag:4'd3},  // R3 rising
    '{ch:2'd1, mode:1'b0, pol:1'b1, tau:8'd0, pch:2'd1, idle:1'b1, len:8'd3, exp:1'b1, tag:4'd3},  // R3 falling
    '{ch:2'd2, mode:1'b0, pol:1'b0, tau:8'd0, pch:2'd3, idle:1'b0, len:8'd3, exp:1'b0, tag:4'd6},  // R6 other ch
    '{ch:2'd3, mode:1'b0, pol:1'b0, tau:8'd0, pch:2'd3, idle:1'b0, len:8'd3, exp:1'b1, tag:4'd6},  // R6 top ch
    '{ch:2'd0, mode:1'b1, pol:1'b0, tau:8'd5, pch:2'd0, idle:1'b0, len:8'd5, exp:1'b1, tag:4'd4},  // R4 exact
    '{ch:2'd0, mode:1'b1, pol:1'b0, tau:8'd5, pch:2'd0, idle:1'b0, len:8'd4, exp:1'b0, tag:4'd4},  // R4 short
    '{ch:2'd2, mode:1'b1, pol:1'b1, tau:8'd3, pch:2'd2, idle:1'b1, len:8'd6, exp:1'b1, tag:4'd5},  // R5 low pulse
    '{ch:2'd2, mode:1'b1, pol:1'b1, tau:8'd3, pch:2'd2, idle:1'b0, len:8'd4, exp:1'b0, tag:4'd5},  // R5 wrong shape
    '{ch:2'd1, mode:1'b1, pol:1'b0, tau:8'd0, pch:2'd1, idle:1'b0, len:8'd1, exp:1'b1, tag:4'd12}, // R12
    '{ch:2'd1, mode:1'b0, pol:1'b1, tau:8'd0, pch:2'd1, idle:1'b0, len:8'd3, exp:1'b1, tag:4'd3}   // R3 trailing fall
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [1:0] ch, input logic md, input logic pl, input int tau);
    cfg_we = 1'b1; cfg_chan = ch; cfg_mode = md; cfg_pol = pl; cfg_width = WIDTH_W'(tau);
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic do_arm();
    arm = 1'b1;
    tick();
    arm = 1'b0;
  endtask

  task automatic do_abort();
    abort = 1'b1;
    tick();
    abort = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int rc;
    repeat (3) tick();
    // R1 reset state
    chk(hold_o == 0 && rel_o == 0 && ts_valid_o == 0, "R1", {hold_o, rel_o, ts_valid_o}, 0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk(hold_o == 0 && rel_o == 0, "R1", {hold_o, rel_o}, 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      din = {NUM_CH{VEC[i].idle}};
      repeat (4) tick();
      write_cfg(VEC[i].ch, VEC[i].mode, VEC[i].pol, int'(VEC[i].tau));
      do_arm();
      rc = 0;
      din[VEC[i].pch] = ~VEC[i].idle;
      for (int k = 0; k < int'(VEC[i].len); k++) begin tick(); rc += int'(rel_o); end
      din[VEC[i].pch] = VEC[i].idle;
      for (int k = 0; k < 6; k++) begin tick(); rc += int'(rel_o); end
      chk(rc == int'(VEC[i].exp), $sformatf("R%0d vec%0d releases", VEC[i].tag, i), rc, VEC[i].exp);
      if (!VEC[i].exp) begin
        chk(hold_o == 1, $sformatf("R%0d vec%0d still holding", VEC[i].tag, i), hold_o, 1);
        do_abort();
      end
      tick();
    end

    // R2, R7, R8: exact latency and timestamp
    din = '0; repeat (4) tick();
    write_cfg(2'd0, 1'b0, 1'b0, 0);
    do_arm();
    chk(hold_o == 1, "R2 hold after arm", hold_o, 1);
    din[0] = 1'b1;
    tick();
    chk(hold_o == 1 && rel_o == 0, "R7 edge1", {hold_o, rel_o}, 2);
    tick();
    chk(hold_o == 1 && rel_o == 0, "R7 edge2", {hold_o, rel_o}, 2);
    tick();
    chk(hold_o == 0 && rel_o == 1, "R7 edge3 release", {hold_o, rel_o}, 1);
    chk(ts_valid_o == 1, "R8 valid strobe", ts_valid_o, 1);
    chk(longint'(ts_o) == bc - 1, "R8 timestamp", ts_o, bc - 1);
    tick();
    chk(rel_o == 0 && ts_valid_o == 0, "R8 single cycle", {rel_o, ts_valid_o}, 0);

    // R11: re-arm on another channel in the same sequence
    write_cfg(2'd2, 1'b0, 1'b0, 0);
    do_arm();
    chk(hold_o == 1, "R11 re-armed", hold_o, 1);
    din[2] = 1'b1;
    rc = 0;
    for (int k = 0; k < 5; k++) begin tick(); rc += int'(rel_o); end
    chk(rc == 1, "R11 release on new channel", rc, 1);

    // R9: plain abort
    din = '0; repeat (4) tick();
    write_cfg(2'd1, 1'b0, 1'b0, 0);
    do_arm();
    do_abort();
    chk(hold_o == 0 && rel_o == 0, "R9 abort to idle", {hold_o, rel_o}, 0);
    din[1] = 1'b1;
    rc = 0;
    for (int k = 0; k < 5; k++) begin tick(); rc += int'(rel_o); end
    chk(rc == 0, "R9 no release after abort", rc, 0);

    // R9: abort in the same cycle as the qualifying edge
    din = '0; repeat (4) tick();
    write_cfg(2'd0, 1'b0, 1'b0, 0);
    do_arm();
    din[0] = 1'b1;
    tick();
    tick();
    abort = 1'b1;
    tick();
    abort = 1'b0;
    chk(hold_o == 0 && rel_o == 0, "R9 collision abort wins", {hold_o, rel_o}, 0);
    rc = 0;
    for (int k = 0; k < 4; k++) begin tick(); rc += int'(rel_o); end
    chk(rc == 0, "R9 collision no late release", rc, 0);

    // R10: configuration write while armed is ignored
    din = '0; repeat (4) tick();
    write_cfg(2'd0, 1'b0, 1'b0, 0);
    do_arm();
    write_cfg(2'd1, 1'b0, 1'b0, 0);
    din[1] = 1'b1;
    rc = 0;
    for (int k = 0; k < 5; k++) begin tick(); rc += int'(rel_o); end
    chk(rc == 0 && hold_o == 1, "R10 new channel ignored", rc, 0);
    din[0] = 1'b1;
    rc = 0;
    for (int k = 0; k < 5; k++) begin tick(); rc += int'(rel_o); end
    chk(rc == 1, "R10 original channel kept", rc, 1);

    finish_run();
  end
endmodule